// File: doc/BRIEF.md
# Banked scratchpad conflict resolver

This block schedules one request from a group of lanes against an on-chip scratchpad that is split into word-interleaved banks, each one word (32 bits) wide. A request carries one word address per lane, an active-lane mask, a write flag and two mode bits. The block turns the request into a sequence of conflict-free waves. In each wave every bank is given at most one distinct word, and the block reports which lanes that wave serves. It keeps issuing waves, one per clock, until every active lane has been served, and then pulses a done flag.

Reads of one word by several lanes are broadcast in a single wave, so a conflict exists only between different words that share a bank. A pairing mode also lets a read serve two words of one bank together when they differ only in the bit just above the bank index. A legacy mode halves the bank count. The block reports the number of waves the request needs as a replay metric. For writes it marks which lane's write actually lands, so that the scratchpad sees one writer per word.

Top module: `bank_conflict_resolver`

## Requirements
- R1: The bank of a word is its address modulo 32 (bits [4:0]) when `legacy_i`=0, and modulo 16 (bits [3:0]) when `legacy_i`=1.
- R2: Within one wave, all served lanes that map to one bank ask for the same word. The exception is a pairing-mode read (R4), where the served words of a bank may differ in bit 5 only.
- R3: Active lanes that read the same word are all served in one wave.
- R4: With `pair_i`=1, `write_i`=0 and `legacy_i`=0, two words whose addresses differ only in bit 5 do not conflict and are served in the same wave. For writes or in legacy mode, `pair_i` has no effect.
- R5: When a bank holds several words, each wave serves the word requested by the lowest-numbered unserved lane in that bank.
- R6: From the cycle after an accepted `start_i`, `replay_o` equals the largest number of distinct words (distinct pair groups under R4) mapped to any one bank among active lanes. It holds that value until the next accepted start, and inactive lanes are ignored.
- R7: Waves occupy consecutive cycles, with `wave_valid_o`=1, starting in the cycle after start. Their number equals `replay_o`. `done_o` is a one-cycle pulse in the cycle after the last wave, and `busy_o` drops after it.
- R8: For a write, when several lanes of one wave write the same word, only the highest-numbered of them has its bit set in `wave_commit_o`. For a read, `wave_commit_o` equals `wave_lanes_o`.
- R9: An empty active mask gives `replay_o`=0, no wave, and `done_o` in the cycle after start.
- R10: Each active lane is served in exactly one wave and inactive lanes are never served. A `start_i` that arrives while `busy_o`=1 is ignored.
- R11: Conflicts are judged only within one request. Two back-to-back requests that touch the same bank with different words each take one wave.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Accept a new request when idle |
| mask_i | input | LANES | Active lane mask |
| addr_i | input | LANES*AW | Word address per lane, lane n at bits [n*AW +: AW] |
| write_i | input | 1 | 1 = write request, 0 = read |
| pair_i | input | 1 | Pairing mode for reads (R4) |
| legacy_i | input | 1 | Half bank count mode (R1) |
| busy_o | output | 1 | Request in progress |
| wave_valid_o | output | 1 | A wave is issued this cycle |
| wave_lanes_o | output | LANES | Lanes served by this wave |
| wave_commit_o | output | LANES | Lanes whose access lands this wave |
| replay_o | output | $clog2(LANES+1) | Waves needed by the last accepted request |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The block is exercised with these input patterns:
- A unit-stride read, which must finish in one wave.
- An all-lanes-same-word read, which separates broadcast from per-lane serialization.
- A stride-2 read, which puts two words in every even bank. It is run plain, in pairing mode, and as a write, so that pairing is seen to help reads only.
- A unit stride in legacy mode, which separates 16-bank from 32-bank mapping.
- A sparse mask with three words in bank 0, which checks lowest-lane wave order and that inactive lanes are not counted.
- Same-word writes, which show that only the highest lane commits.
- An empty mask, a start issued while busy, and back-to-back requests, which cover the boundary and independence cases.

// File: rtl/rcr_pkg.sv
package rcr_pkg;
   typedef logic [31:0] word_t;
   typedef enum logic {RC_IDLE, RC_RUN} rc_state_e;

   // true when two words fall in the same bank given bb index bits
   function automatic logic same_bank(word_t a, word_t b, int unsigned bb);
      word_t m;
      m = (word_t'(1) << bb) - word_t'(1);
      return ((a ^ b) & m) == '0;
   endfunction

   // true when two words need no separate wave; merge drops bit bb
   function automatic logic same_group(word_t a, word_t b, logic merge, int unsigned bb);
      word_t d;
      d = a ^ b;
      if (merge) d = d & ~(word_t'(1) << bb);
      return d == '0;
   endfunction
endpackage

// File: rtl/rcr_wave_sel.sv
module rcr_wave_sel
   import rcr_pkg::*;
#(
   parameter int unsigned LANES = 32,
   parameter int unsigned AW    = 10,
   parameter int unsigned BB    = 5,
   parameter int unsigned LBB   = 4
) (
   input  logic [LANES*AW-1:0] addr_i,
   input  logic [LANES-1:0]    pend_i,
   input  logic                legacy_i,
   input  logic                merge_i,
   input  logic                write_i,
   output logic [LANES-1:0]    served_o,
   output logic [LANES-1:0]    commit_o
);
   word_t w [LANES];

   for (genvar g = 0; g < LANES; g++) begin : g_unpack
      assign w[g] = word_t'(addr_i[g*AW +: AW]);
   end

   logic [LANES-1:0] leader;
   int unsigned      bb;

   always_comb begin
      bb = legacy_i ? LBB : BB;
      // lowest pending lane of each bank leads it
      for (int k = 0; k < LANES; k++) begin
         leader[k] = pend_i[k];
         for (int j = 0; j < k; j++)
            if (pend_i[j] && same_bank(w[j], w[k], bb)) leader[k] = 1'b0;
      end
      // a lane rides along when its group matches its bank leader
      for (int l = 0; l < LANES; l++) begin
         served_o[l] = 1'b0;
         for (int k = 0; k < LANES; k++)
            if (pend_i[l] && leader[k] && same_bank(w[k], w[l], bb)
                && same_group(w[k], w[l], merge_i, BB))
               served_o[l] = 1'b1;
      end
      // for writes only the top lane per word lands
      for (int l = 0; l < LANES; l++) begin
         commit_o[l] = served_o[l];
         if (write_i)
            for (int h = l + 1; h < LANES; h++)
               if (served_o[h] && (w[h] == w[l])) commit_o[l] = 1'b0;
      end
   end
endmodule

// File: rtl/rcr_depth.sv
module rcr_depth
   import rcr_pkg::*;
#(
   parameter int unsigned LANES = 32,
   parameter int unsigned AW    = 10,
   parameter int unsigned BANKS = 32,
   parameter int unsigned BB    = 5,
   parameter int unsigned LBB   = 4,
   localparam int unsigned CW   = $clog2(LANES + 1)
) (
   input  logic [LANES*AW-1:0] addr_i,
   input  logic [LANES-1:0]    mask_i,
   input  logic                legacy_i,
   input  logic                merge_i,
   output logic [CW-1:0]       depth_o
);
   word_t w [LANES];

   for (genvar g = 0; g < LANES; g++) begin : g_unpack
      assign w[g] = word_t'(addr_i[g*AW +: AW]);
   end

   logic [LANES-1:0] first;
   logic [CW-1:0]    cnt;
   int unsigned      bb;
   word_t            bmask;

   always_comb begin
      bb    = legacy_i ? LBB : BB;
      bmask = (word_t'(1) << bb) - word_t'(1);
      // first lane of every distinct group
      for (int l = 0; l < LANES; l++) begin
         first[l] = mask_i[l];
         for (int j = 0; j < l; j++)
            if (mask_i[j] && same_group(w[j], w[l], merge_i, BB)) first[l] = 1'b0;
      end
      depth_o = '0;
      for (int b = 0; b < BANKS; b++) begin
         cnt = '0;
         for (int l = 0; l < LANES; l++)
            if (first[l] && ((w[l] & bmask) == word_t'(b))) cnt = cnt + CW'(1);
         if (cnt > depth_o) depth_o = cnt;
      end
   end
endmodule

// File: rtl/bank_conflict_resolver.sv
module bank_conflict_resolver
   import rcr_pkg::*;
#(
   parameter int unsigned LANES        = 32,
   parameter int unsigned AW           = 10,
   parameter int unsigned BANKS        = 32,
   parameter int unsigned LEGACY_BANKS = 16,
   localparam int unsigned BB          = $clog2(BANKS),
   localparam int unsigned LBB         = $clog2(LEGACY_BANKS),
   localparam int unsigned CW          = $clog2(LANES + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start_i,
   input  logic [LANES-1:0]    mask_i,
   input  logic [LANES*AW-1:0] addr_i,
   input  logic                write_i,
   input  logic                pair_i,
   input  logic                legacy_i,
   output logic                busy_o,
   output logic                wave_valid_o,
   output logic [LANES-1:0]    wave_lanes_o,
   output logic [LANES-1:0]    wave_commit_o,
   output logic [CW-1:0]       replay_o,
   output logic                done_o
);
   if ((1 << BB) != BANKS || BANKS < 2) begin : g_bad_banks
      $error("BANKS must be a power of two");
   end
   if ((1 << LBB) != LEGACY_BANKS || LEGACY_BANKS >= BANKS) begin : g_bad_legacy
      $error("LEGACY_BANKS must be a smaller power of two");
   end
   if (AW > 32 || AW <= BB) begin : g_bad_aw
      $error("AW must exceed the bank bits and fit a word");
   end

   rc_state_e           state_q;
   logic [LANES-1:0]    pending_q, mask_q;
   logic [LANES*AW-1:0] addr_q;
   logic                write_q, pair_q, legacy_q;
   logic                merge;
   logic [LANES-1:0]    served, commit;

   assign merge = pair_q && !write_q && !legacy_q;

   rcr_wave_sel #(.LANES(LANES), .AW(AW), .BB(BB), .LBB(LBB)) u_sel (
      .addr_i   (addr_q),
      .pend_i   (pending_q),
      .legacy_i (legacy_q),
      .merge_i  (merge),
      .write_i  (write_q),
      .served_o (served),
      .commit_o (commit)
   );

   rcr_depth #(.LANES(LANES), .AW(AW), .BANKS(BANKS), .BB(BB), .LBB(LBB)) u_depth (
      .addr_i   (addr_q),
      .mask_i   (mask_q),
      .legacy_i (legacy_q),
      .merge_i  (merge),
      .depth_o  (replay_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= RC_IDLE;
         pending_q <= '0;
         mask_q    <= '0;
         addr_q    <= '0;
         write_q   <= 1'b0;
         pair_q    <= 1'b0;
         legacy_q  <= 1'b0;
      end else if (state_q == RC_IDLE) begin
         if (start_i) begin
            state_q   <= RC_RUN;
            pending_q <= mask_i;
            mask_q    <= mask_i;
            addr_q    <= addr_i;
            write_q   <= write_i;
            pair_q    <= pair_i;
            legacy_q  <= legacy_i;
         end
      end else if (pending_q == '0) begin
         state_q <= RC_IDLE;
      end else begin
         pending_q <= pending_q & ~served;
      end
   end

   assign busy_o        = (state_q == RC_RUN);
   assign wave_valid_o  = busy_o && (pending_q != '0);
   assign done_o        = busy_o && (pending_q == '0);
   assign wave_lanes_o  = wave_valid_o ? served : '0;
   assign wave_commit_o = wave_valid_o ? commit : '0;
endmodule

// File: rtl/rcr_checker.sv
module rcr_checker
   import rcr_pkg::*;
#(
   parameter int unsigned LANES = 32,
   parameter int unsigned AW    = 10,
   parameter int unsigned BB    = 5,
   parameter int unsigned LBB   = 4
) (
   input logic                clk,
   input logic                rst_n,
   input logic                start_i,
   input logic [LANES-1:0]    mask_i,
   input logic                busy_o,
   input logic                wave_valid_o,
   input logic [LANES-1:0]    wave_lanes_o,
   input logic [LANES-1:0]    wave_commit_o,
   input logic                done_o,
   input logic [LANES-1:0]    mask_q,
   input logic [LANES*AW-1:0] addr_q,
   input logic                legacy_q,
   input logic                merge
);
   logic [LANES-1:0] acc_q;
   logic             clash;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 acc_q <= '0;
      else if (!busy_o && start_i) acc_q <= '0;
      else if (wave_valid_o)      acc_q <= acc_q | wave_lanes_o;
   end

   always_comb begin
      clash = 1'b0;
      for (int i = 0; i < LANES; i++)
         for (int j = i + 1; j < LANES; j++)
            if (wave_lanes_o[i] && wave_lanes_o[j]
                && same_bank(word_t'(addr_q[i*AW +: AW]), word_t'(addr_q[j*AW +: AW]), legacy_q ? LBB : BB)
                && !same_group(word_t'(addr_q[i*AW +: AW]), word_t'(addr_q[j*AW +: AW]), merge, BB))
               clash = 1'b1;
   end

   a_r2_one_word_per_bank: assert property (@(posedge clk) disable iff (!rst_n)
      wave_valid_o |-> !clash);
   a_r10_no_reserve: assert property (@(posedge clk) disable iff (!rst_n)
      wave_valid_o |-> (wave_lanes_o & acc_q) == '0);
   a_r10_active_only: assert property (@(posedge clk) disable iff (!rst_n)
      wave_valid_o |-> (wave_lanes_o & ~mask_q) == '0);
   a_r7_wave_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
      wave_valid_o |-> wave_lanes_o != '0);
   a_r7_done_complete: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> acc_q == mask_q);
   a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o && !busy_o);
   a_r8_commit_in_wave: assert property (@(posedge clk) disable iff (!rst_n)
      wave_valid_o |-> (wave_commit_o & ~wave_lanes_o) == '0);
   a_r9_empty_done: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && start_i && mask_i == '0) |=> done_o);
endmodule

bind bank_conflict_resolver rcr_checker #(.LANES(LANES), .AW(AW), .BB(BB), .LBB(LBB)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .start_i       (start_i),
   .mask_i        (mask_i),
   .busy_o        (busy_o),
   .wave_valid_o  (wave_valid_o),
   .wave_lanes_o  (wave_lanes_o),
   .wave_commit_o (wave_commit_o),
   .done_o        (done_o),
   .mask_q        (mask_q),
   .addr_q        (addr_q),
   .legacy_q      (legacy_q),
   .merge         (merge)
);

// File: tb/sim_bank_conflict_resolver.sv
module sim_bank_conflict_resolver;
   localparam int LANES = 32;
   localparam int AW    = 10;
   localparam int CW    = $clog2(LANES + 1);

   logic                clk = 1'b0;
   logic                rst_n = 1'b0;
   logic                start_i = 1'b0;
   logic [LANES-1:0]    mask_i = '0;
   logic [LANES*AW-1:0] addr_i = '0;
   logic                write_i = 1'b0, pair_i = 1'b0, legacy_i = 1'b0;
   logic                busy_o, wave_valid_o, done_o;
   logic [LANES-1:0]    wave_lanes_o, wave_commit_o;
   logic [CW-1:0]       replay_o;

   bank_conflict_resolver #(.LANES(LANES), .AW(AW)) u0 (.*);

   always #2 clk = ~clk;

   int errors = 0, checks = 0;
   logic [LANES-1:0] wl [16];
   logic [LANES-1:0] wc [16];
   int nw, done_cyc, rep;
   bit gap, finished = 0;

   task automatic chk(bit ok, string req, longint act, longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [LANES*AW-1:0] stride(int step, int base);
      logic [LANES*AW-1:0] v = '0;
      for (int l = 0; l < LANES; l++) v[l*AW +: AW] = AW'(base + l*step);
      return v;
   endfunction

   task automatic run_req(logic [LANES-1:0] m, logic [LANES*AW-1:0] a, logic wr, logic pr, logic lg);
      int cyc = 0;
      bit got = 0;
      @(negedge clk);
      mask_i = m; addr_i = a; write_i = wr; pair_i = pr; legacy_i = lg; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      nw = 0; gap = 0; done_cyc = 0;
      while (!got && cyc < 40) begin
         cyc++;
         if (done_o) begin got = 1; done_cyc = cyc; rep = int'(replay_o); end
         else if (wave_valid_o && nw < 16) begin wl[nw] = wave_lanes_o; wc[nw] = wave_commit_o; nw++; end
         else gap = 1;
         if (!got) @(negedge clk);
      end
      chk(got && !gap && done_cyc == nw + 1, "R7 waves then done", done_cyc, nw + 1);
      chk(rep == nw, "R7 wave count equals replay", nw, rep);
      @(negedge clk);
      chk(!done_o && !busy_o, "R7 done single pulse", {done_o, busy_o}, 0);
   endtask

   task automatic t_reset();
      chk(!busy_o && !done_o && !wave_valid_o && replay_o == 0, "reset state", {busy_o, done_o, wave_valid_o}, 0);
   endtask

   task automatic t_unit_stride();
      run_req('1, stride(1, 0), 0, 0, 0);
      chk(rep == 1 && wl[0] == '1, "R1 unit stride one wave", wl[0], 32'hFFFFFFFF);
   endtask

   task automatic t_broadcast();
      run_req('1, stride(0, 7), 0, 0, 0);
      chk(rep == 1 && wl[0] == '1, "R3 broadcast", rep, 1);
      chk(wc[0] == '1, "R8 read commit equals served", wc[0], 32'hFFFFFFFF);
   endtask

   task automatic t_stride2();
      run_req('1, stride(2, 0), 0, 0, 0);
      chk(rep == 2, "R6 stride2 depth", rep, 2);
      chk(wl[0] == 32'h0000FFFF && wl[1] == 32'hFFFF0000, "R2 stride2 waves", wl[0], 32'h0000FFFF);
      run_req('1, stride(2, 0), 0, 1, 0);
      chk(rep == 1 && wl[0] == '1, "R4 pair read merges", rep, 1);
      run_req('1, stride(2, 0), 1, 1, 0);
      chk(rep == 2 && wc[0] == 32'h0000FFFF, "R4 pair ignored on write", rep, 2);
   endtask

   task automatic t_legacy();
      run_req('1, stride(1, 0), 0, 0, 1);
      chk(rep == 2 && wl[0] == 32'h0000FFFF, "R1 legacy 16 banks", wl[0], 32'h0000FFFF);
   endtask

   task automatic t_priority();
      logic [LANES*AW-1:0] a = stride(1, 0);
      a[3*AW +: AW] = 64; a[5*AW +: AW] = 32; a[7*AW +: AW] = 0; a[9*AW +: AW] = 64;
      run_req(32'h2A8, a, 0, 0, 0);
      chk(rep == 3, "R6 inactive lanes ignored", rep, 3);
      chk(wl[0] == 32'h208, "R5 first wave lowest lane", wl[0], 32'h208);
      chk(wl[1] == 32'h20 && wl[2] == 32'h80, "R5 later waves", wl[1], 32'h20);
   endtask

   task automatic t_write_same();
      run_req(32'h844, stride(0, 5), 1, 0, 0);
      chk(rep == 1 && wl[0] == 32'h844, "R8 same-word write one wave", wl[0], 32'h844);
      chk(wc[0] == 32'h800, "R8 highest lane commits", wc[0], 32'h800);
   endtask

   task automatic t_empty();
      run_req('0, stride(1, 0), 0, 0, 0);
      chk(rep == 0 && nw == 0 && done_cyc == 1, "R9 empty mask", done_cyc, 1);
   endtask

   task automatic t_ignore_busy();
      @(negedge clk);
      mask_i = '1; addr_i = stride(2, 0); write_i = 0; pair_i = 0; legacy_i = 0; start_i = 1;
      @(negedge clk);
      chk(wave_lanes_o == 32'h0000FFFF, "R10 first wave", wave_lanes_o, 32'h0000FFFF);
      mask_i = 32'h1; addr_i = '0;
      @(negedge clk);
      start_i = 0;
      chk(wave_lanes_o == 32'hFFFF0000, "R10 start while busy ignored", wave_lanes_o, 32'hFFFF0000);
      @(negedge clk);
      chk(done_o && replay_o == 2, "R10 done after ignored start", replay_o, 2);
      @(negedge clk);
   endtask

   task automatic t_independent();
      logic [LANES*AW-1:0] a = '0;
      a[AW +: AW] = 32;
      run_req(32'h1, a, 0, 0, 0);
      chk(rep == 1, "R11 first request", rep, 1);
      run_req(32'h2, a, 0, 0, 0);
      chk(rep == 1 && wl[0] == 32'h2, "R11 second request independent", wl[0], 32'h2);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_unit_stride();
      t_broadcast();
      t_stride2();
      t_legacy();
      t_priority();
      t_write_same();
      t_empty();
      t_ignore_busy();
      t_independent();
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(4 * 100000);
      if (!finished) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule